// File: doc/BRIEF.md
# Machine-Mode Control and Status Register Unit

This block is the control and status register file of a 32-bit core that runs in machine and user privilege. Each cycle it may accept one request: a 12-bit register address, a read or write flag, write data and the privilege level the core is running at. One cycle later it returns the value the register held before the request, together with a flag that marks the access as an illegal instruction. Legality comes from the address bits and from which registers exist and can be written. Nothing else is consulted.

It holds the machine status word, the interrupt enable, pending and delegation words, the trap vector, exception return address, trap cause, trap value and scratch words. It also holds a constant ISA descriptor and a constant hart identifier. It derives a 64-bit cycle count and a slower 64-bit time count from an instruction count input plus an offset input. When the status, enable or pending word is written, the unit raises a one-cycle request so that the core re-evaluates its pending interrupts.

Top module: `mcsr_unit`

## Requirements
- R1: Privilege levels are encoded as 0 for user and 3 for machine. The minimum privilege for an address is its bits [9:8]. If `cur_priv` is numerically below that value, the access is illegal.
- R2: A write to any address whose bits [11:10] are both 1 is illegal, whatever the privilege.
- R3: These accesses are illegal: an address with no register, or a write to a register without a write path. Registers without a write path are the ISA descriptor 0x301, cycle 0xB00/0xB80, time 0xC01/0xC81 and hart id 0xF14. An illegal access changes no register, returns read data 0 and raises no re-evaluation request.
- R4: The status word (0x300) resets to 0. A write updates only the bits set in 0x807FF9DD. A read returns the stored value ANDed with 0x807FF9DD.
- R5: A write to the interrupt enable word (0x304) updates only the bits in 0xBBB. A write to the pending word (0x344) updates only the bits in 0xB3B, so pending bit 7 always stays 0.
- R6: The delegation word (0x303) is writable through mask 0xBBB. Reads of the enable and pending words return their stored value ANDed with the delegation word.
- R7: 0xB00 returns bits [31:0] of `instr_count + cycle_offset`, and 0xB80 returns bits [63:32].
- R8: The user-readable time words 0xC01 and 0xC81 return the low and high halves of `(instr_count + cycle_offset) / 3050`.
- R9: `irq_recheck` is high for exactly the response cycle of a legal write to 0x300, 0x304 or 0x344, and is low otherwise.
- R10: `rsp_valid`, `rsp_illegal` and `rsp_rdata` are registered together and appear in the cycle after the request. For a write, `rsp_rdata` is the value before the write. The words 0x305, 0x340, 0x341, 0x342 and 0x343 are plain 32-bit read/write storage.
- R11: 0x301 reads the parameter `MISA_VAL` (default 0x40101104), and 0xF14 reads the parameter `HART_ID`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 32 | Write data |
| cur_priv | input | 2 | Current privilege level |
| instr_count | input | 64 | Retired instruction count |
| cycle_offset | input | 64 | Offset added to the instruction count |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Access raised an illegal instruction |
| rsp_rdata | output | 32 | Value before the access |
| irq_recheck | output | 1 | Interrupt re-evaluation pulse |

## Verification
Two functions can land on the same response cycle: the read-old-value path and the masked write path of the same register. Each interrupt and status write therefore checks both the returned old value and the re-evaluation pulse in that response, and a following read checks the masked new value. The legality decode and the re-evaluation pulse also coincide: status writes attempted from user privilege must return illegal with no pulse, and a later machine read must show the stored word unchanged.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int XLEN = 32;
    localparam int CNTW = 64;

    localparam logic [XLEN-1:0] STATUS_WMASK = 32'h807F_F9DD;
    localparam logic [XLEN-1:0] IRQ_WMASK    = 32'h0000_0BBB;
    localparam logic [XLEN-1:0] PEND_WMASK   = IRQ_WMASK & ~32'h0000_0080;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_STATUS, SEL_ISA, SEL_DELEG, SEL_IEN, SEL_VEC,
        SEL_SCRATCH, SEL_EPC, SEL_CAUSE, SEL_TVAL, SEL_IPEND,
        SEL_CYC_LO, SEL_CYC_HI, SEL_TIME_LO, SEL_TIME_HI, SEL_HART
    } csr_sel_e;

    typedef struct packed {
        csr_sel_e sel;
        logic     writable;
    } csr_decode_t;

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] rdata;
        logic            recheck;
    } csr_rsp_t;

    function automatic csr_decode_t decode_addr(input logic [11:0] a);
        csr_decode_t d;
        d.writable = 1'b1;
        case (a)
            12'h300: d.sel = SEL_STATUS;
            12'h301: begin d.sel = SEL_ISA;     d.writable = 1'b0; end
            12'h303: d.sel = SEL_DELEG;
            12'h304: d.sel = SEL_IEN;
            12'h305: d.sel = SEL_VEC;
            12'h340: d.sel = SEL_SCRATCH;
            12'h341: d.sel = SEL_EPC;
            12'h342: d.sel = SEL_CAUSE;
            12'h343: d.sel = SEL_TVAL;
            12'h344: d.sel = SEL_IPEND;
            12'hB00: begin d.sel = SEL_CYC_LO;  d.writable = 1'b0; end
            12'hB80: begin d.sel = SEL_CYC_HI;  d.writable = 1'b0; end
            12'hC01: begin d.sel = SEL_TIME_LO; d.writable = 1'b0; end
            12'hC81: begin d.sel = SEL_TIME_HI; d.writable = 1'b0; end
            12'hF14: begin d.sel = SEL_HART;    d.writable = 1'b0; end
            default: begin d.sel = SEL_NONE;    d.writable = 1'b0; end
        endcase
        return d;
    endfunction

    function automatic logic [XLEN-1:0] masked_merge(
        input logic [XLEN-1:0] old_v,
        input logic [XLEN-1:0] new_v,
        input logic [XLEN-1:0] mask
    );
        return (old_v & ~mask) | (new_v & mask);
    endfunction

endpackage

// File: rtl/mcsr_access_check.sv
module mcsr_access_check
    import mcsr_pkg::*;
(
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [1:0]  cur_priv,
    output csr_sel_e    sel,
    output logic        legal
);
    csr_decode_t dec;
    logic        priv_ok;
    logic        ro_region;

    always_comb begin
        dec       = decode_addr(req_addr);
        priv_ok   = cur_priv >= req_addr[9:8];
        ro_region = req_addr[11:10] == 2'b11;
        sel       = dec.sel;
        legal     = priv_ok && (dec.sel != SEL_NONE)
                    && !(req_write && (ro_region || !dec.writable));
    end
endmodule

// File: rtl/mcsr_counters.sv
module mcsr_counters
    import mcsr_pkg::*;
#(
    parameter int TIME_DIV = 3050
) (
    input  logic [CNTW-1:0] instr_count,
    input  logic [CNTW-1:0] cycle_offset,
    output logic [CNTW-1:0] cyc,
    output logic [CNTW-1:0] tim
);
    localparam logic [CNTW-1:0] DIVISOR = CNTW'(TIME_DIV);

    always_comb begin
        cyc = instr_count + cycle_offset;
        tim = cyc / DIVISOR;
    end
endmodule

// File: rtl/mcsr_regs.sv
module mcsr_regs
    import mcsr_pkg::*;
#(
    parameter logic [31:0] MISA_VAL = 32'h4010_1104,
    parameter logic [31:0] HART_ID  = 32'h0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  csr_sel_e        sel,
    input  logic [XLEN-1:0] wdata,
    input  logic [CNTW-1:0] cyc,
    input  logic [CNTW-1:0] tim,
    output logic [XLEN-1:0] rdata
);
    localparam int NPLAIN = 5;

    logic [XLEN-1:0] status_q, deleg_q, ien_q, ipend_q;
    logic [XLEN-1:0] plain_q [NPLAIN];
    csr_sel_e        plain_sel [NPLAIN];

    assign plain_sel[0] = SEL_VEC;
    assign plain_sel[1] = SEL_SCRATCH;
    assign plain_sel[2] = SEL_EPC;
    assign plain_sel[3] = SEL_CAUSE;
    assign plain_sel[4] = SEL_TVAL;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            deleg_q  <= '0;
            ien_q    <= '0;
            ipend_q  <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_STATUS: status_q <= masked_merge(status_q, wdata, STATUS_WMASK);
                SEL_DELEG:  deleg_q  <= masked_merge(deleg_q, wdata, IRQ_WMASK);
                SEL_IEN:    ien_q    <= masked_merge(ien_q, wdata, IRQ_WMASK);
                SEL_IPEND:  ipend_q  <= masked_merge(ipend_q, wdata, PEND_WMASK);
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)
                plain_q[g] <= '0;
            else if (wr_en && sel == plain_sel[g])
                plain_q[g] <= wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_STATUS:  rdata = status_q & STATUS_WMASK;
            SEL_ISA:     rdata = MISA_VAL;
            SEL_DELEG:   rdata = deleg_q;
            SEL_IEN:     rdata = ien_q & deleg_q;
            SEL_IPEND:   rdata = ipend_q & deleg_q;
            SEL_VEC:     rdata = plain_q[0];
            SEL_SCRATCH: rdata = plain_q[1];
            SEL_EPC:     rdata = plain_q[2];
            SEL_CAUSE:   rdata = plain_q[3];
            SEL_TVAL:    rdata = plain_q[4];
            SEL_CYC_LO:  rdata = cyc[31:0];
            SEL_CYC_HI:  rdata = cyc[63:32];
            SEL_TIME_LO: rdata = tim[31:0];
            SEL_TIME_HI: rdata = tim[63:32];
            SEL_HART:    rdata = HART_ID;
            default:     rdata = '0;
        endcase
    end

    // R5: pending bit 7 cannot be set by a write
    assert_pend_bit7_ro_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en && sel == SEL_IPEND |=> ipend_q[7] == $past(ipend_q[7]));

    // R3: without a write enable the status and interrupt words hold
    assert_hold_no_write_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(status_q) && $stable(ien_q) && $stable(ipend_q) && $stable(deleg_q));

    // R4: bits outside the status mask survive a status write
    assert_status_mask_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en && sel == SEL_STATUS |=>
            (status_q & ~STATUS_WMASK) == ($past(status_q) & ~STATUS_WMASK));
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
    import mcsr_pkg::*;
#(
    parameter logic [31:0] MISA_VAL = 32'h4010_1104,
    parameter logic [31:0] HART_ID  = 32'h0,
    parameter int          TIME_DIV = 3050
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    input  logic [1:0]  cur_priv,
    input  logic [63:0] instr_count,
    input  logic [63:0] cycle_offset,
    output logic        rsp_valid,
    output logic        rsp_illegal,
    output logic [31:0] rsp_rdata,
    output logic        irq_recheck
);
    csr_sel_e        sel;
    logic            legal;
    logic            wr_en;
    logic [CNTW-1:0] cyc, tim;
    logic [XLEN-1:0] rd_val;
    csr_rsp_t        rsp_d, rsp_q;

    mcsr_access_check u_check (
        .req_write (req_write),
        .req_addr  (req_addr),
        .cur_priv  (cur_priv),
        .sel       (sel),
        .legal     (legal)
    );

    mcsr_counters #(.TIME_DIV(TIME_DIV)) u_cnt (
        .instr_count  (instr_count),
        .cycle_offset (cycle_offset),
        .cyc          (cyc),
        .tim          (tim)
    );

    assign wr_en = req_valid && req_write && legal;

    mcsr_regs #(.MISA_VAL(MISA_VAL), .HART_ID(HART_ID)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .sel   (sel),
        .wdata (req_wdata),
        .cyc   (cyc),
        .tim   (tim),
        .rdata (rd_val)
    );

    always_comb begin
        rsp_d.valid   = req_valid;
        rsp_d.illegal = req_valid && !legal;
        rsp_d.rdata   = (req_valid && legal) ? rd_val : '0;
        rsp_d.recheck = wr_en && (sel == SEL_STATUS || sel == SEL_IEN || sel == SEL_IPEND);
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_illegal = rsp_q.illegal;
    assign rsp_rdata   = rsp_q.rdata;
    assign irq_recheck = rsp_q.recheck;

    // R1: too little privilege for the address gives illegal
    assert_priv_low_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid && (cur_priv < req_addr[9:8]) |=> rsp_illegal);

    // R2: writes into the read-only region are illegal
    assert_ro_write_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write && req_addr[11:10] == 2'b11 |=> rsp_illegal);

    // R3: illegal responses carry zero data and no recheck pulse
    assert_illegal_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_illegal |-> rsp_rdata == '0 && !irq_recheck);

    // R10: a response follows each request by one cycle
    assert_rsp_timing_R10: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R9: recheck only appears with a valid response
    assert_recheck_valid_R9: assert property (@(posedge clk) disable iff (rst)
        irq_recheck |-> rsp_valid && !rsp_illegal);
endmodule

// File: tb/mcsr_unit_tb.sv
module mcsr_unit_tb_top;

    typedef struct packed {
        logic        wr;
        logic [1:0]  priv;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic        ill;
        logic [31:0] rd;
        logic        rc;
    } vec_t;

    localparam int NV = 36;
    localparam logic [31:0] HART = 32'h0000_0007;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd3, 12'h300, 32'h0,         1'b0, 32'h0,         1'b0},
        '{1'b1, 2'd3, 12'h300, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b1},
        '{1'b0, 2'd3, 12'h300, 32'h0,         1'b0, 32'h807F_F9DD, 1'b0},
        '{1'b1, 2'd3, 12'h303, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'h303, 32'h0,         1'b0, 32'h0000_0BBB, 1'b0},
        '{1'b1, 2'd3, 12'h304, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b1},
        '{1'b0, 2'd3, 12'h304, 32'h0,         1'b0, 32'h0000_0BBB, 1'b0},
        '{1'b1, 2'd3, 12'h344, 32'hFFFF_FFFF, 1'b0, 32'h0,         1'b1},
        '{1'b0, 2'd3, 12'h344, 32'h0,         1'b0, 32'h0000_0B3B, 1'b0},
        '{1'b1, 2'd3, 12'h305, 32'h1234_5679, 1'b0, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'h305, 32'h0,         1'b0, 32'h1234_5679, 1'b0},
        '{1'b1, 2'd3, 12'h340, 32'hA5A5_A5A5, 1'b0, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'h340, 32'h0,         1'b0, 32'hA5A5_A5A5, 1'b0},
        '{1'b0, 2'd3, 12'h301, 32'h0,         1'b0, 32'h4010_1104, 1'b0},
        '{1'b1, 2'd3, 12'h301, 32'h1,         1'b1, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'hF14, 32'h0,         1'b0, HART,          1'b0},
        '{1'b0, 2'd3, 12'h7C0, 32'h0,         1'b1, 32'h0,         1'b0},
        '{1'b0, 2'd0, 12'h300, 32'h0,         1'b1, 32'h0,         1'b0},
        '{1'b1, 2'd0, 12'h305, 32'h0,         1'b1, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'h305, 32'h0,         1'b0, 32'h1234_5679, 1'b0},
        '{1'b1, 2'd3, 12'hC01, 32'h5,         1'b1, 32'h0,         1'b0},
        '{1'b1, 2'd3, 12'hB00, 32'h5,         1'b1, 32'h0,         1'b0},
        '{1'b0, 2'd0, 12'hC01, 32'h0,         1'b0, 32'h0,         1'b0},
        '{1'b1, 2'd0, 12'h300, 32'h0,         1'b1, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'h300, 32'h0,         1'b0, 32'h807F_F9DD, 1'b0},
        '{1'b1, 2'd3, 12'h341, 32'hDEAD_BEEF, 1'b0, 32'h0,         1'b0},
        '{1'b1, 2'd3, 12'h341, 32'h0000_0001, 1'b0, 32'hDEAD_BEEF, 1'b0},
        '{1'b1, 2'd3, 12'h342, 32'h8000_000B, 1'b0, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'h342, 32'h0,         1'b0, 32'h8000_000B, 1'b0},
        '{1'b1, 2'd3, 12'h343, 32'h0000_0055, 1'b0, 32'h0,         1'b0},
        '{1'b0, 2'd3, 12'h343, 32'h0,         1'b0, 32'h0000_0055, 1'b0},
        '{1'b1, 2'd3, 12'h303, 32'h0000_000F, 1'b0, 32'h0000_0BBB, 1'b0},
        '{1'b0, 2'd3, 12'h304, 32'h0,         1'b0, 32'h0000_000B, 1'b0},
        '{1'b0, 2'd3, 12'h344, 32'h0,         1'b0, 32'h0000_000B, 1'b0},
        '{1'b1, 2'd3, 12'h300, 32'h0,         1'b0, 32'h807F_F9DD, 1'b1},
        '{1'b0, 2'd3, 12'h300, 32'h0,         1'b0, 32'h0,         1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cur_priv = 2'd3;
    logic [63:0] instr_count = '0, cycle_offset = '0;
    logic        rsp_valid, rsp_illegal, irq_recheck;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    mcsr_unit #(.HART_ID(HART)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cur_priv(cur_priv),
        .instr_count(instr_count), .cycle_offset(cycle_offset),
        .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal),
        .rsp_rdata(rsp_rdata), .irq_recheck(irq_recheck)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one request at a falling edge; the response is sampled one cycle later
    task automatic access(input logic wr, input logic [1:0] pv, input logic [11:0] a,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; cur_priv = pv; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input logic ill, input logic [31:0] rd,
                              input logic rc);
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " illegal"}, 32'(rsp_illegal), 32'(ill));
        check({req, " rdata"}, rsp_rdata, rd);
        check({req, " recheck"}, 32'(irq_recheck), 32'(rc));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] sum;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 reset valid", 32'(rsp_valid), 32'd0);
        check("R9 reset recheck", 32'(irq_recheck), 32'd0);

        // Table walk covering R1 to R6, R9 to R11
        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].priv, VECS[i].addr, VECS[i].wdata);
            expect_rsp($sformatf("R1-vector %0d addr %h", i, VECS[i].addr),
                       VECS[i].ill, VECS[i].rd, VECS[i].rc);
        end

        // R10: idle cycle gives no response
        @(negedge clk);
        check("R10 idle valid", 32'(rsp_valid), 32'd0);

        // R7 cycle halves
        instr_count = 64'h0000_0001_2345_6789; cycle_offset = 64'h10;
        sum = instr_count + cycle_offset;
        access(1'b0, 2'd3, 12'hB00, 0); expect_rsp("R7 cycle lo", 1'b0, sum[31:0], 1'b0);
        access(1'b0, 2'd3, 12'hB80, 0); expect_rsp("R7 cycle hi", 1'b0, sum[63:32], 1'b0);
        access(1'b0, 2'd2, 12'hB00, 0); expect_rsp("R1 cycle lo priv2", 1'b1, 32'h0, 1'b0);

        // R8 time halves and divisor boundary
        sum = sum / 64'd3050;
        access(1'b0, 2'd0, 12'hC01, 0); expect_rsp("R8 time lo", 1'b0, sum[31:0], 1'b0);
        access(1'b0, 2'd0, 12'hC81, 0); expect_rsp("R8 time hi", 1'b0, sum[63:32], 1'b0);
        instr_count = 64'd3000; cycle_offset = 64'd49;
        access(1'b0, 2'd0, 12'hC01, 0); expect_rsp("R8 time 3049", 1'b0, 32'd0, 1'b0);
        cycle_offset = 64'd50;
        access(1'b0, 2'd0, 12'hC01, 0); expect_rsp("R8 time 3050", 1'b0, 32'd1, 1'b0);
        instr_count = 64'hFFFF_FFFF_FFFF_FFFF; cycle_offset = 64'd0;
        sum = instr_count / 64'd3050;
        access(1'b0, 2'd0, 12'hC81, 0); expect_rsp("R8 time hi max", 1'b0, sum[63:32], 1'b0);

        // R2: write to read-only region even at machine level
        access(1'b1, 2'd3, 12'hF14, 32'h9); expect_rsp("R2 hartid write", 1'b1, 32'h0, 1'b0);
        access(1'b0, 2'd3, 12'hF14, 0);     expect_rsp("R11 hartid after", 1'b0, HART, 1'b0);

        // R4: status reset to zero after a mid-run reset
        access(1'b1, 2'd3, 12'h300, 32'h0000_0008);
        expect_rsp("R4 set status", 1'b0, 32'h0, 1'b1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(1'b0, 2'd3, 12'h300, 0); expect_rsp("R4 status after reset", 1'b0, 32'h0, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule